// File: doc/BRIEF.md
# Real-Time Clock Alarm Match Unit

This unit holds the four alarm registers of a real-time clock (seconds, minutes, hours and day of month) and compares them against the running BCD time-of-day once per one-second tick. When the compare succeeds on a tick, it emits a single-cycle interrupt pulse. Timekeeping itself, interrupt enable gating and any flag bookkeeping are done elsewhere. The block only sees the current time fields and the tick strobe.

Bit 7 of every alarm register is a "don't care" flag for that field. The combination of flags picks how often the alarm repeats:
- all clear gives once a month;
- the date flag alone gives once a day;
- date and hour give once an hour;
- date, hour and minute give once a minute;
- every other pattern gives an alarm on every tick.

Writes carrying an out-of-range BCD value are refused, so the stored alarm always holds a legal time.

Top module: `rtca_alarm_top`

## Requirements
- R1: While reset is asserted and after it is released, all four alarm registers read back 0x00 and `alarm_irq` is low.
- R2: Register select encoding for `wr_sel` and `rd_sel` is 0 = seconds, 1 = minutes, 2 = hours, 3 = date. `rd_data` combinationally shows the full stored byte of the selected register. A write changes only the selected register, and an accepted write stores all 8 bits of `wr_data`.
- R3: A seconds or minutes write is accepted only if bits 6:4 × 10 + bits 3:0 is at most 59.
- R4: An hours write is accepted only if bits 5:4 × 10 + bits 3:0 is at most 23.
- R5: A date write is accepted only if bits 5:0 are not all zero.
- R6: A refused write leaves the target register unchanged.
- R7: Monthly mode applies when the bit-7 flags of all four registers are clear. The alarm hits when date bits 5:0, hour bits 5:0, minute bits 6:0 and second bits 6:0 all equal `tod_date`, `tod_hour`, `tod_min` and `tod_sec`.
- R8: Daily mode applies when only the date flag is set. The alarm hits when hour, minute and second match, whatever the date.
- R9: Hourly mode (date and hour flags set) hits on a minute and second match. Per-minute mode (date, hour and minute flags set) hits on a seconds match.
- R10: Any other flag pattern, including the seconds flag alone, makes every tick a hit.
- R11: `alarm_irq` is high for exactly the one cycle after a clock cycle in which `tick` was high and the alarm hit. It is never high without a preceding tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the alarm registers |
| wr_sel | input | 2 | Register selected for writing |
| wr_data | input | 8 | Write data: bit 7 is the flag, the rest is the BCD value |
| rd_sel | input | 2 | Register selected for readback |
| rd_data | output | 8 | Stored byte of the selected register |
| tod_sec | input | 7 | Current seconds, BCD |
| tod_min | input | 7 | Current minutes, BCD |
| tod_hour | input | 6 | Current hours, BCD |
| tod_date | input | 6 | Current day of month, BCD |
| tick | input | 1 | One-second strobe, one cycle wide |
| alarm_irq | output | 1 | Single-cycle alarm pulse |

## Verification
The bench targets the range edges of each field:
- seconds 0x59 against 0x5A;
- hours 0x23 against 0x24 and 0x3F;
- a date whose low six bits are zero but whose bit 6 or bit 7 is set.

A validator that looked at the wrong bit slice would store an illegal alarm or refuse a legal one, and the readback would show it. Each repeat mode is driven with exactly one field mismatching. A rate decoder that compared a flagged field, or ignored an unflagged one, would then pulse when it should stay quiet, or stay quiet when it should pulse. Isolated ticks with idle cycles in between show whether the pulse is stretched or fires without a tick. Mixed flag patterns such as seconds-only and date-plus-minute show whether a decoder wrongly treats them as one of the four compare modes.

// File: rtl/rtca_pkg.sv
`timescale 1ns/1ps
package rtca_pkg;
  parameter int unsigned REG_W    = 8;
  parameter int unsigned NUM_FLD  = 4;
  parameter int unsigned SEL_W    = $clog2(NUM_FLD);
  parameter int unsigned FLAG_POS = REG_W - 1;
  parameter int unsigned SEC_W    = 7;
  parameter int unsigned MIN_W    = 7;
  parameter int unsigned HOUR_W   = 6;
  parameter int unsigned DATE_W   = 6;
  parameter int unsigned SEC_MAX  = 59;
  parameter int unsigned MIN_MAX  = 59;
  parameter int unsigned HOUR_MAX = 23;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2,
    FLD_DATE = 2'd3
  } fld_e;

  typedef enum logic [2:0] {
    RATE_MONTH = 3'd0,
    RATE_DAY   = 3'd1,
    RATE_HOUR  = 3'd2,
    RATE_MIN   = 3'd3,
    RATE_SEC   = 3'd4
  } rate_e;

  // decimal value of a BCD field occupying the low w bits of d
  function automatic int unsigned bcd_val(input logic [REG_W-1:0] d, input int unsigned w);
    int unsigned raw;
    int unsigned hi;
    raw = 32'(d);
    hi  = (raw >> 4) & ((32'd1 << (w - 4)) - 32'd1);
    return hi * 10 + (raw & 32'hF);
  endfunction

  function automatic logic wr_ok(input fld_e k, input logic [REG_W-1:0] d);
    case (k)
      FLD_SEC:  return bcd_val(d, SEC_W)  <= SEC_MAX;
      FLD_MIN:  return bcd_val(d, MIN_W)  <= MIN_MAX;
      FLD_HOUR: return bcd_val(d, HOUR_W) <= HOUR_MAX;
      FLD_DATE: return d[DATE_W-1:0] != '0;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rtca_field_reg.sv
`timescale 1ns/1ps
module rtca_field_reg
  import rtca_pkg::*;
#(
  parameter fld_e KIND = FLD_SEC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);
  logic ld_en;

  // load enable: selected and in range for this field kind
  always_comb begin
    ld_en = sel_wr && wr_ok(KIND, wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (ld_en) begin
      q <= wr_data;
    end
  end
endmodule

// File: rtl/rtca_rate_decode.sv
`timescale 1ns/1ps
module rtca_rate_decode
  import rtca_pkg::*;
(
  input  logic [NUM_FLD-1:0] flags,  // bit index follows fld_e
  output rate_e              rate
);
  always_comb begin
    case (flags)
      4'b0000: rate = RATE_MONTH;
      4'b1000: rate = RATE_DAY;
      4'b1100: rate = RATE_HOUR;
      4'b1110: rate = RATE_MIN;
      default: rate = RATE_SEC;
    endcase
  end
endmodule

// File: rtl/rtca_match.sv
`timescale 1ns/1ps
module rtca_match
  import rtca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  rate_e             rate,
  input  logic [SEC_W-1:0]  al_sec,
  input  logic [MIN_W-1:0]  al_min,
  input  logic [HOUR_W-1:0] al_hour,
  input  logic [DATE_W-1:0] al_date,
  input  logic [SEC_W-1:0]  tod_sec,
  input  logic [MIN_W-1:0]  tod_min,
  input  logic [HOUR_W-1:0] tod_hour,
  input  logic [DATE_W-1:0] tod_date,
  output logic              irq
);
  logic eq_s, eq_m, eq_h, eq_d;
  logic hit;
  logic irq_d;

  always_comb begin
    eq_s = (al_sec  == tod_sec);
    eq_m = (al_min  == tod_min);
    eq_h = (al_hour == tod_hour);
    eq_d = (al_date == tod_date);
    case (rate)
      RATE_MONTH: hit = eq_d && eq_h && eq_m && eq_s;
      RATE_DAY:   hit = eq_h && eq_m && eq_s;
      RATE_HOUR:  hit = eq_m && eq_s;
      RATE_MIN:   hit = eq_s;
      default:    hit = 1'b1;
    endcase
    irq_d = tick && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end
endmodule

// File: rtl/rtca_alarm_top.sv
`timescale 1ns/1ps
module rtca_alarm_top
  import rtca_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [REG_W-1:0]  rd_data,
  input  logic [SEC_W-1:0]  tod_sec,
  input  logic [MIN_W-1:0]  tod_min,
  input  logic [HOUR_W-1:0] tod_hour,
  input  logic [DATE_W-1:0] tod_date,
  input  logic              tick,
  output logic              alarm_irq
);
  logic [NUM_FLD-1:0][REG_W-1:0] alm_q;
  logic [NUM_FLD-1:0]            flags;
  rate_e                         rate;

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    localparam fld_e K = fld_e'(SEL_W'(i));
    logic sel_wr;
    always_comb begin
      sel_wr = wr_en && (wr_sel == SEL_W'(i));
    end
    rtca_field_reg #(.KIND(K)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_wr  (sel_wr),
      .wr_data (wr_data),
      .q       (alm_q[i])
    );
    assign flags[i] = alm_q[i][FLAG_POS];
  end

  always_comb begin
    rd_data = alm_q[rd_sel];
  end

  rtca_rate_decode u_rate (
    .flags (flags),
    .rate  (rate)
  );

  rtca_match u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rate     (rate),
    .al_sec   (alm_q[FLD_SEC][SEC_W-1:0]),
    .al_min   (alm_q[FLD_MIN][MIN_W-1:0]),
    .al_hour  (alm_q[FLD_HOUR][HOUR_W-1:0]),
    .al_date  (alm_q[FLD_DATE][DATE_W-1:0]),
    .tod_sec  (tod_sec),
    .tod_min  (tod_min),
    .tod_hour (tod_hour),
    .tod_date (tod_date),
    .irq      (alarm_irq)
  );
endmodule

// File: rtl/rtca_alarm_chk.sv
`timescale 1ns/1ps
module rtca_alarm_chk
  import rtca_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [SEL_W-1:0]              wr_sel,
  input logic [REG_W-1:0]              wr_data,
  input logic [SEC_W-1:0]              tod_sec,
  input logic                          tick,
  input logic [NUM_FLD-1:0][REG_W-1:0] alm_q,
  input logic                          alarm_irq
);
  // R11
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(tick));

  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_irq && !tick) |=> !alarm_irq);

  // R3
  sec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 &&
     (32'(wr_data[6:4]) * 32'd10 + 32'(wr_data[3:0]) > 32'd59))
    |=> $stable(alm_q[0]));

  // R5
  date_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3 && wr_data[5:0] == 6'd0) |=> $stable(alm_q[3]));

  // R2
  hour_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_sel != 2'd2) |=> $stable(alm_q[2]));

  // R10
  every_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && alm_q[0][7]) |=> alarm_irq);

  // R7
  month_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !alm_q[0][7] && !alm_q[1][7] && !alm_q[2][7] && !alm_q[3][7] &&
     alm_q[0][6:0] != tod_sec) |=> !alarm_irq);
endmodule

bind rtca_alarm_top rtca_alarm_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .tod_sec   (tod_sec),
  .tick      (tick),
  .alm_q     (alm_q),
  .alarm_irq (alarm_irq)
);

// File: tb/tb_rtca_alarm_top.sv
`timescale 1ns/1ps
module tb_rtca_alarm_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [1:0] rd_sel;
  logic [7:0] rd_data;
  logic [6:0] tod_sec;
  logic [6:0] tod_min;
  logic [5:0] tod_hour;
  logic [5:0] tod_date;
  logic       tick;
  logic       alarm_irq;

  int    vec = 0;
  int    bad = 0;
  bit    chk_on = 0;
  bit    finished = 0;
  string tag = "R1";

  logic [7:0] mdl_reg [4];
  logic       mdl_irq;

  always #5 clk = ~clk;

  rtca_alarm_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tod_sec(tod_sec), .tod_min(tod_min),
    .tod_hour(tod_hour), .tod_date(tod_date), .tick(tick), .alarm_irq(alarm_irq)
  );

  // behavioural reference: range rules and repeat modes from the requirements
  function automatic bit mdl_ok(input int sel, input int d);
    int v;
    case (sel)
      0, 1: begin v = ((d >> 4) & 7) * 10 + (d & 15); return v <= 59; end
      2:    begin v = ((d >> 4) & 3) * 10 + (d & 15); return v <= 23; end
      default: return (d & 63) != 0;
    endcase
  endfunction

  function automatic bit mdl_hit();
    bit fs, fm, fh, fd, es, em, eh, ed;
    fs = mdl_reg[0][7]; fm = mdl_reg[1][7]; fh = mdl_reg[2][7]; fd = mdl_reg[3][7];
    es = (int'(mdl_reg[0]) & 127) == int'(tod_sec);
    em = (int'(mdl_reg[1]) & 127) == int'(tod_min);
    eh = (int'(mdl_reg[2]) & 63)  == int'(tod_hour);
    ed = (int'(mdl_reg[3]) & 63)  == int'(tod_date);
    if (!fd && !fh && !fm && !fs) return ed && eh && em && es;
    if ( fd && !fh && !fm && !fs) return eh && em && es;
    if ( fd &&  fh && !fm && !fs) return em && es;
    if ( fd &&  fh &&  fm && !fs) return es;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) mdl_reg[i] <= 8'h00;
      mdl_irq <= 1'b0;
    end else begin
      mdl_irq <= tick && mdl_hit();
      if (wr_en && mdl_ok(int'(wr_sel), int'(wr_data))) mdl_reg[wr_sel] <= wr_data;
    end
  end

  // compare one ns before each rising edge
  always @(negedge clk) begin
    #4;
    if (chk_on && !finished) begin
      vec++;
      if (alarm_irq !== mdl_irq) begin
        bad++;
        $display("FAIL %s alarm_irq act=%0b exp=%0b at %0t", tag, alarm_irq, mdl_irq, $time);
      end
      vec++;
      if (rd_data !== mdl_reg[rd_sel]) begin
        bad++;
        $display("FAIL %s rd_data[%0d] act=%02h exp=%02h at %0t", tag, rd_sel, rd_data,
                 mdl_reg[rd_sel], $time);
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d; rd_sel = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_tod(input logic [6:0] s, input logic [6:0] m,
                         input logic [5:0] h, input logic [5:0] d);
    @(negedge clk);
    tod_sec = s; tod_min = m; tod_hour = h; tod_date = d;
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'h00; rd_sel = 2'd0;
    tod_sec = 7'h00; tod_min = 7'h00; tod_hour = 6'h00; tod_date = 6'h01; tick = 1'b0;
    @(posedge clk);
    chk_on = 1;
    // R1: reset values, irq low even with a tick
    tag = "R1";
    for (int i = 0; i < 4; i++) begin @(negedge clk); rd_sel = 2'(i); end
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); rd_sel = 2'(i); end

    // R2: select encoding and full-byte store
    tag = "R2";
    wr(2'd0, 8'h12); wr(2'd1, 8'h34); wr(2'd2, 8'h05); wr(2'd3, 8'h17);
    for (int i = 0; i < 4; i++) begin @(negedge clk); rd_sel = 2'(i); end

    // R3: seconds/minutes range
    tag = "R3";
    wr(2'd0, 8'h59); wr(2'd0, 8'h0F); wr(2'd0, 8'hD9); wr(2'd1, 8'h45);
    tag = "R6";
    wr(2'd0, 8'h5A); wr(2'd0, 8'h7F); wr(2'd1, 8'h60);
    // R4: hours range
    tag = "R4";
    wr(2'd2, 8'h23); wr(2'd2, 8'hA0);
    tag = "R6";
    wr(2'd2, 8'h24); wr(2'd2, 8'h3F);
    // R5: date nonzero
    tag = "R5";
    wr(2'd3, 8'h01); wr(2'd3, 8'hBF);
    tag = "R6";
    wr(2'd3, 8'h00); wr(2'd3, 8'hC0);

    // R7: monthly compare
    tag = "R7";
    wr(2'd0, 8'h30); wr(2'd1, 8'h15); wr(2'd2, 8'h08); wr(2'd3, 8'h21);
    set_tod(7'h30, 7'h15, 6'h08, 6'h21); one_tick();
    set_tod(7'h31, 7'h15, 6'h08, 6'h21); one_tick();
    set_tod(7'h30, 7'h16, 6'h08, 6'h21); one_tick();
    set_tod(7'h30, 7'h15, 6'h09, 6'h21); one_tick();
    set_tod(7'h30, 7'h15, 6'h08, 6'h22); one_tick();

    // R11: match without a tick gives nothing; isolated ticks give isolated pulses
    tag = "R11";
    set_tod(7'h30, 7'h15, 6'h08, 6'h21); idle(4);
    one_tick(); idle(2); one_tick();

    // R8: daily
    tag = "R8";
    wr(2'd3, 8'hA1);
    set_tod(7'h30, 7'h15, 6'h08, 6'h05); one_tick();
    set_tod(7'h30, 7'h15, 6'h07, 6'h05); one_tick();

    // R9: hourly, then per-minute
    tag = "R9";
    wr(2'd2, 8'h88);
    set_tod(7'h30, 7'h15, 6'h13, 6'h05); one_tick();
    set_tod(7'h30, 7'h14, 6'h13, 6'h05); one_tick();
    wr(2'd1, 8'h95);
    set_tod(7'h30, 7'h44, 6'h13, 6'h05); one_tick();
    set_tod(7'h29, 7'h44, 6'h13, 6'h05); one_tick();

    // R10: other flag patterns fire on every tick
    tag = "R10";
    wr(2'd1, 8'h15); wr(2'd2, 8'h08); wr(2'd3, 8'h21); wr(2'd0, 8'hB0);
    set_tod(7'h01, 7'h02, 6'h03, 6'h04); one_tick(); one_tick();
    wr(2'd0, 8'h30); wr(2'd3, 8'hA1); wr(2'd1, 8'h95);
    one_tick();
    wr(2'd2, 8'h88); wr(2'd0, 8'hB0);
    one_tick();
    idle(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog %s act=hung exp=done", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule